// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor that runs each instruction over several clock cycles and shares one memory between instruction fetch and data access. On every cycle it drives the datapath's select lines and write enables. These include the memory read and write strobes, the instruction-register load, the program-counter update enables, the ALU operand and mode selects, and the register-file write controls. It supports four instruction kinds: word load, word store, register-register ALU operation and branch-if-equal.

The sequencer is a Moore machine. A 4-bit state register holds the current step. The next step depends on the state and on the 6-bit opcode field of the instruction register. The control word depends on the state alone. The surrounding datapath, the ALU function decoding and the memory sit outside this block.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the sequencer enters the fetch step (state 0) and drives the fetch control word on the next cycle.
- R2: The fetch step (state 0) drives the following: `mem_rd`=1, `ir_load`=1, `pc_wr_en`=1, `mem_addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=1, `alu_mode`=0, `pc_next_sel`=0. Every other control is 0.
- R3: Fetch is always followed by the decode step (state 1). Decode drives `alu_a_sel`=0, `alu_b_sel`=3 and `alu_mode`=0, with every other control 0.
- R4: From decode, opcode 0x23 (load) or 0x2B (store) leads to the address step (state 2). The address step drives `alu_a_sel`=1, `alu_b_sel`=2 and `alu_mode`=0. From the address step, opcode 0x23 leads to state 3 and any other opcode leads to state 5.
- R5: The load path runs state 2 → 3 → 4 → 0. State 3 drives `mem_rd`=1 and `mem_addr_sel`=1. State 4 drives `rf_wr_en`=1, `wb_from_mem`=1 and `rf_dst_sel`=0.
- R6: The store path runs state 2 → 5 → 0. State 5 drives `mem_wr`=1 and `mem_addr_sel`=1.
- R7: Opcode 0x00 in decode leads to state 6 and then state 7, which returns to 0. State 6 drives `alu_a_sel`=1, `alu_b_sel`=0 and `alu_mode`=2. State 7 drives `rf_wr_en`=1, `rf_dst_sel`=1 and `wb_from_mem`=0.
- R8: Opcode 0x04 in decode leads to state 8 and then back to 0. State 8 drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_mode`=1, `pc_wr_cond`=1 and `pc_next_sel`=1.
- R9: Any other opcode in decode returns the sequencer to fetch on the next cycle.
- R10: The opcode has no effect in states 0, 3, 4, 5, 6, 7 and 8. The successor of each of these states is fixed.
- R11: `mem_rd` and `mem_wr` are never high together, and neither are `pc_wr_en` and `rf_wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_op | input | 6 | Opcode field of the instruction register |
| pc_wr_en | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write if the ALU result is zero |
| mem_addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_load | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data: 0 = ALU result, 1 = memory data |
| pc_next_sel | output | 1 | PC source: 0 = ALU output, 1 = ALU result register |
| alu_mode | output | 2 | 0 = add, 1 = subtract, 2 = function-field driven |
| alu_a_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 0 = reg B, 1 = constant 4, 2 = sign-extended imm, 3 = imm shifted by 2 |
| rf_wr_en | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register: 0 = rt field, 1 = rd field |

## Verification
A wrong state register value shows at the ports in the same cycle. Every reachable state has its own control word, so a bad state appears at once as an unexpected combination of strobes and selects. A wrong transition shows one clock after the decode or address step that caused it. The bench rebuilds the state from the observed control word and compares it with the step order each opcode requires. It also changes the opcode in the cycles where it must be ignored, to catch a transition that samples the opcode in the wrong state.

// File: rtl/mc_ctrl_pkg.sv
// Package: shared state encoding, control-word layout and per-state
// control values for the multicycle control sequencer.
// Assumes a 4-bit state code. Unused codes drive an all-zero word.
package mc_ctrl_pkg;

    localparam int ST_W = 4;
    localparam int OP_W = 6;
    localparam int NUM_CODES = 1 << ST_W;

    localparam logic [ST_W-1:0] ST_FETCH  = 4'd0;
    localparam logic [ST_W-1:0] ST_DECODE = 4'd1;
    localparam logic [ST_W-1:0] ST_MADDR  = 4'd2;
    localparam logic [ST_W-1:0] ST_LDRD   = 4'd3;
    localparam logic [ST_W-1:0] ST_LDWB   = 4'd4;
    localparam logic [ST_W-1:0] ST_STWR   = 4'd5;
    localparam logic [ST_W-1:0] ST_REXE   = 4'd6;
    localparam logic [ST_W-1:0] ST_RWB    = 4'd7;
    localparam logic [ST_W-1:0] ST_BRCMP  = 4'd8;

    typedef enum logic [1:0] {
        OPK_RTYPE  = 2'd0,
        OPK_MEM    = 2'd1,
        OPK_BRANCH = 2'd2,
        OPK_OTHER  = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_ld;
        logic       wb_mem;
        logic       pc_sel;
        logic [1:0] alu_mode;
        logic       a_sel;
        logic [1:0] b_sel;
        logic       rf_wr;
        logic       dst_sel;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Control word for one state code. Fields not set here stay zero.
    function automatic ctl_t ctl_for(input logic [ST_W-1:0] s);
        ctl_t c;
        c = '0;
        case (s)
            ST_FETCH: begin
                c.mem_rd = 1'b1;
                c.ir_ld  = 1'b1;
                c.pc_wr  = 1'b1;
                c.b_sel  = 2'd1;
            end
            ST_DECODE: begin
                c.b_sel  = 2'd3;
            end
            ST_MADDR: begin
                c.a_sel  = 1'b1;
                c.b_sel  = 2'd2;
            end
            ST_LDRD: begin
                c.mem_rd   = 1'b1;
                c.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                c.rf_wr  = 1'b1;
                c.wb_mem = 1'b1;
            end
            ST_STWR: begin
                c.mem_wr   = 1'b1;
                c.addr_sel = 1'b1;
            end
            ST_REXE: begin
                c.a_sel    = 1'b1;
                c.alu_mode = 2'd2;
            end
            ST_RWB: begin
                c.rf_wr   = 1'b1;
                c.dst_sel = 1'b1;
            end
            ST_BRCMP: begin
                c.a_sel    = 1'b1;
                c.alu_mode = 2'd1;
                c.pc_cond  = 1'b1;
                c.pc_sel   = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mc_op_class.sv
// Module: opcode classifier.
// Sorts the 6-bit opcode into the instruction kinds the sequencer
// branches on, and flags a load for the address-step split.
// Assumes the opcode values are supplied as parameters.
module mc_op_class
    import mc_ctrl_pkg::*;
#(
    parameter logic [OP_W-1:0] OPC_RTYPE  = 6'h00,
    parameter logic [OP_W-1:0] OPC_LOAD   = 6'h23,
    parameter logic [OP_W-1:0] OPC_STORE  = 6'h2B,
    parameter logic [OP_W-1:0] OPC_BRANCH = 6'h04
) (
    input  logic [OP_W-1:0] op,
    output op_kind_e        kind,
    output logic            is_load
);

    // Purpose: map the opcode to its instruction kind.
    always_comb begin
        if (op == OPC_RTYPE)                       kind = OPK_RTYPE;
        else if (op == OPC_LOAD || op == OPC_STORE) kind = OPK_MEM;
        else if (op == OPC_BRANCH)                 kind = OPK_BRANCH;
        else                                       kind = OPK_OTHER;
    end

    // Purpose: identify the load opcode.
    always_comb is_load = (op == OPC_LOAD);

endmodule

// File: rtl/mc_next_state.sv
// Module: next-state function of the sequencer.
// Purely combinational. Uses the opcode only in decode and in the
// address step. Unused state codes fall back to fetch.
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  logic [ST_W-1:0] cur,
    input  op_kind_e        kind,
    input  logic            is_load,
    output logic [ST_W-1:0] nxt
);

    // Purpose: choose the successor of the current step.
    always_comb begin
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (kind)
                    OPK_MEM:    nxt = ST_MADDR;
                    OPK_RTYPE:  nxt = ST_REXE;
                    OPK_BRANCH: nxt = ST_BRCMP;
                    default:    nxt = ST_FETCH;
                endcase
            end
            ST_MADDR:  nxt = is_load ? ST_LDRD : ST_STWR;
            ST_LDRD:   nxt = ST_LDWB;
            ST_REXE:   nxt = ST_RWB;
            ST_LDWB, ST_STWR, ST_RWB, ST_BRCMP: nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctl_rom.sv
// Module: output table of the sequencer.
// Builds one control word per state code, as a ROM addressed by the
// state register, and reads out the entry for the current state.
module mc_ctl_rom
    import mc_ctrl_pkg::*;
(
    input  logic [ST_W-1:0] cur,
    output ctl_t            ctl
);

    ctl_t table_q [NUM_CODES];

    // One entry per state code, computed from the package function.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_row
        assign table_q[i] = ctl_for(ST_W'(i));
    end

    // Purpose: select the entry for the current state.
    always_comb ctl = table_q[cur];

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Module: top of the multicycle control sequencer.
// Holds the 4-bit state register and drives the datapath controls from
// the current state alone (Moore). The reset is synchronous and
// active low, and it forces the fetch step.
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter logic [OP_W-1:0] OPC_RTYPE  = 6'h00,
    parameter logic [OP_W-1:0] OPC_LOAD   = 6'h23,
    parameter logic [OP_W-1:0] OPC_STORE  = 6'h2B,
    parameter logic [OP_W-1:0] OPC_BRANCH = 6'h04
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] instr_op,
    output logic       pc_wr_en,
    output logic       pc_wr_cond,
    output logic       mem_addr_sel,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       ir_load,
    output logic       wb_from_mem,
    output logic       pc_next_sel,
    output logic [1:0] alu_mode,
    output logic       alu_a_sel,
    output logic [1:0] alu_b_sel,
    output logic       rf_wr_en,
    output logic       rf_dst_sel
);

    logic [ST_W-1:0] state_q;
    logic [ST_W-1:0] state_d;
    op_kind_e        kind;
    logic            is_load;
    ctl_t            ctl;

    mc_op_class #(
        .OPC_RTYPE (OPC_RTYPE),
        .OPC_LOAD  (OPC_LOAD),
        .OPC_STORE (OPC_STORE),
        .OPC_BRANCH(OPC_BRANCH)
    ) u_class (
        .op     (instr_op),
        .kind   (kind),
        .is_load(is_load)
    );

    mc_next_state u_next (
        .cur    (state_q),
        .kind   (kind),
        .is_load(is_load),
        .nxt    (state_d)
    );

    mc_ctl_rom u_rom (
        .cur(state_q),
        .ctl(ctl)
    );

    // Purpose: state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Purpose: unpack the control word onto the ports.
    always_comb begin
        pc_wr_en     = ctl.pc_wr;
        pc_wr_cond   = ctl.pc_cond;
        mem_addr_sel = ctl.addr_sel;
        mem_rd       = ctl.mem_rd;
        mem_wr       = ctl.mem_wr;
        ir_load      = ctl.ir_ld;
        wb_from_mem  = ctl.wb_mem;
        pc_next_sel  = ctl.pc_sel;
        alu_mode     = ctl.alu_mode;
        alu_a_sel    = ctl.a_sel;
        alu_b_sel    = ctl.b_sel;
        rf_wr_en     = ctl.rf_wr;
        rf_dst_sel   = ctl.dst_sel;
    end

endmodule

// File: rtl/mc_ctrl_chk.sv
// Module: assertion checker for the control sequencer.
// Watches the state register and the output strobes. Attached to the
// top module with the bind statement at the end of this file.
module mc_ctrl_chk #(
    parameter logic [5:0] OPC_RTYPE  = 6'h00,
    parameter logic [5:0] OPC_LOAD   = 6'h23,
    parameter logic [5:0] OPC_STORE  = 6'h2B,
    parameter logic [5:0] OPC_BRANCH = 6'h04
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] state_q,
    input logic [5:0] instr_op,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       pc_wr_en,
    input logic       rf_wr_en
);

    logic known_op;
    assign known_op = (instr_op == OPC_RTYPE) || (instr_op == OPC_LOAD) ||
                      (instr_op == OPC_STORE) || (instr_op == OPC_BRANCH);

    AST_RESET_FETCH: assert property (@(posedge clk) !rst_n |=> state_q == 4'd0); // R1
    AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (!rst_n) state_q == 4'd0 |=> state_q == 4'd1); // R3
    AST_MEMOP_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (state_q == 4'd1 && (instr_op == OPC_LOAD || instr_op == OPC_STORE)) |=> state_q == 4'd2); // R4
    AST_LOAD_WB: assert property (@(posedge clk) disable iff (!rst_n) state_q == 4'd3 |=> state_q == 4'd4); // R5
    AST_STORE_DONE: assert property (@(posedge clk) disable iff (!rst_n) state_q == 4'd5 |=> state_q == 4'd0); // R6
    AST_RTYPE_WB: assert property (@(posedge clk) disable iff (!rst_n) state_q == 4'd6 |=> state_q == 4'd7); // R7
    AST_BRANCH_DONE: assert property (@(posedge clk) disable iff (!rst_n) state_q == 4'd8 |=> state_q == 4'd0); // R8
    AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == 4'd1 && !known_op) |=> state_q == 4'd0); // R9
    AST_FIXED_SUCC: assert property (@(posedge clk) disable iff (!rst_n) (state_q == 4'd4 || state_q == 4'd7) |=> state_q == 4'd0); // R10
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R11
    AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pc_wr_en && rf_wr_en)); // R11

endmodule

bind mc_ctrl_fsm mc_ctrl_chk #(
    .OPC_RTYPE (OPC_RTYPE),
    .OPC_LOAD  (OPC_LOAD),
    .OPC_STORE (OPC_STORE),
    .OPC_BRANCH(OPC_BRANCH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .instr_op(instr_op),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .pc_wr_en(pc_wr_en),
    .rf_wr_en(rf_wr_en)
);

// File: tb/mc_ctrl_fsm_tb.sv
// Bench: directed step-order checks per opcode, then seeded random
// opcode streams checked against a reference model of the sequencer.
module mc_ctrl_fsm_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] instr_op = 6'h00;
    logic       pc_wr_en, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_load;
    logic       wb_from_mem, pc_next_sel, alu_a_sel, rf_wr_en, rf_dst_sel;
    logic [1:0] alu_mode, alu_b_sel;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mc_ctrl_fsm u_dut (
        .clk(clk), .rst_n(rst_n), .instr_op(instr_op),
        .pc_wr_en(pc_wr_en), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
        .wb_from_mem(wb_from_mem), .pc_next_sel(pc_next_sel), .alu_mode(alu_mode),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_wr_en(rf_wr_en),
        .rf_dst_sel(rf_dst_sel)
    );

    // Observed vector: pc_wr, cond, addr, rd, wr, ir, wbmem, pcsel, mode[2], a, b[2], rfwr, dst
    wire [14:0] obs = {pc_wr_en, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_load,
                       wb_from_mem, pc_next_sel, alu_mode, alu_a_sel, alu_b_sel,
                       rf_wr_en, rf_dst_sel};

    // Expected control vector per state, written from the requirements.
    function automatic logic [14:0] exp_vec(input int s);
        case (s)
            0: return 15'b1_0_0_1_0_1_0_0_00_0_01_0_0;
            1: return 15'b0_0_0_0_0_0_0_0_00_0_11_0_0;
            2: return 15'b0_0_0_0_0_0_0_0_00_1_10_0_0;
            3: return 15'b0_0_1_1_0_0_0_0_00_0_00_0_0;
            4: return 15'b0_0_0_0_0_0_1_0_00_0_00_1_0;
            5: return 15'b0_0_1_0_1_0_0_0_00_0_00_0_0;
            6: return 15'b0_0_0_0_0_0_0_0_10_1_00_0_0;
            7: return 15'b0_0_0_0_0_0_0_0_00_0_00_1_1;
            8: return 15'b0_1_0_0_0_0_0_1_01_1_00_0_0;
            default: return 15'h7fff;
        endcase
    endfunction

    // Reference successor function.
    function automatic int ref_next(input int s, input logic [5:0] op);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'h23 || op == 6'h2B) return 2;
                if (op == 6'h00) return 6;
                if (op == 6'h04) return 8;
                return 0;
            end
            2: return (op == 6'h23) ? 3 : 5;
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check_state(input string tag, input int s);
        checks++;
        if (obs !== exp_vec(s)) begin
            errors++;
            $display("FAIL %s state %0d actual %b expected %b", tag, s, obs, exp_vec(s));
        end
        if (mem_rd && mem_wr) begin
            errors++;
            $display("FAIL R11 actual rd=%b wr=%b expected not both", mem_rd, mem_wr);
        end
    endtask

    // Apply op, take one edge, check the given expected state.
    task automatic step(input logic [5:0] op, input int exp_s, input string tag);
        instr_op = op;
        @(posedge clk);
        #5;
        model = exp_s;
        check_state(tag, exp_s);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4242);
        // R1: reset state
        repeat (2) @(posedge clk);
        #5;
        check_state("R1", 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Load: 0-1-2-3-4-0, with opcode disturbed where ignored (R10)
        step(6'h23, 1, "R3");
        step(6'h23, 2, "R4");
        step(6'h23, 3, "R5");
        step(6'h04, 4, "R10");
        step(6'h2B, 0, "R10");
        // Store: 0-1-2-5-0
        step(6'h2B, 1, "R3");
        step(6'h2B, 2, "R4");
        step(6'h2B, 5, "R6");
        step(6'h00, 0, "R6");
        // R-format: 0-1-6-7-0
        step(6'h00, 1, "R3");
        step(6'h00, 6, "R7");
        step(6'h23, 7, "R10");
        step(6'h04, 0, "R7");
        // Branch: 0-1-8-0
        step(6'h04, 1, "R3");
        step(6'h04, 8, "R8");
        step(6'h00, 0, "R8");
        // Unknown opcode in decode returns to fetch (R9)
        step(6'h3F, 1, "R3");
        step(6'h3F, 0, "R9");
        step(6'h02, 1, "R3");
        step(6'h02, 0, "R9");
        // Mid-instruction reset (R1)
        step(6'h00, 1, "R3");
        step(6'h00, 6, "R7");
        rst_n = 1'b0;
        step(6'h00, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // Random opcode stream against the reference model.
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op;
            int pick;
            int nxt;
            pick = int'($urandom % 5);
            case (pick)
                0: op = 6'h00;
                1: op = 6'h23;
                2: op = 6'h2B;
                3: op = 6'h04;
                default: op = 6'($urandom % 64);
            endcase
            nxt = ref_next(model, op);
            if (model == 1 && nxt == 0) step(op, nxt, "R9");
            else if (model != 1 && model != 2) step(op, nxt, (nxt == 0) ? "R10" : tag_of(nxt));
            else step(op, nxt, tag_of(nxt));
        end

        done = 1'b1;
        finish_run();
    end

endmodule